// File: doc/BRIEF.md
# Decimal Adjust Unit

This combinational block corrects the result of a plain binary add, subtract, multiply or divide step so that it stays in decimal form. It takes a 16-bit accumulator made of a high byte and a low byte, plus a carry flag and a half-carry flag (the carry out of the low digit). A 3-bit operation code picks one of six corrections. Two corrections work on packed decimal, where each byte holds two digits. Four work on unpacked decimal, where each byte holds one digit in its low nibble; ASCII digits count as unpacked once their high nibble is ignored.

The block does not do the binary arithmetic. A datapath does the add or subtract first, and this unit then fixes the low byte, the high byte and the flags in the same cycle. The packed corrections change only the low byte. The unpacked add and subtract corrections move a decimal carry or borrow into the high byte. The multiply correction splits a binary product of up to 255 into a tens digit and a units digit. The divide correction joins two unpacked digits into one binary value before a division. The block does not check for invalid digits: it applies the same correction rules to them.

Top module: `decimal_adjust_unit`

## Requirements
- R1: Packed add correction (op 0): when the low nibble of the incoming low byte is above 9 or the half-carry input is 1, 6 is added to the low byte (mod 256) and half-carry out is 1; otherwise half-carry out is 0.
- R2: Packed add correction (op 0): when the incoming low byte is above 0x99 or carry in is 1, a further 0x60 is added and carry out is 1; otherwise carry out is 0. Example: 0x9A with clear flags gives 0x00, carry 1, half-carry 1.
- R3: Packed subtract correction (op 1): when the low nibble of the incoming low byte is above 9 or half-carry in is 1, 6 is subtracted from the low byte (mod 256) and half-carry out is 1; otherwise half-carry out is 0.
- R4: Packed subtract correction (op 1): when the incoming low byte is above 0x9F or carry in is 1, a further 0x60 is subtracted and carry out is 1; otherwise carry out is 0. Example: 0xF9 with both flags set gives 0x93.
- R5: Both packed corrections (op 0 and op 1) leave the high byte unchanged.
- R6: Unpacked add correction (op 2): when the low nibble of the low byte is above 9 or half-carry in is 1, 6 is added to the low byte and 1 to the high byte (each mod 256). Example: 0x006A gives 0x0100.
- R7: Unpacked subtract correction (op 3): under the same condition, 6 is subtracted from the low byte and 1 from the high byte (each mod 256). Example: 0x00FF gives 0xFF09.
- R8: For op 2 and op 3, the high nibble of the output low byte is always 0, and carry out and half-carry out are both 1 when a correction was made and both 0 when none was made.
- R9: Multiply correction (op 4): the output high byte is the incoming low byte divided by 10, the output low byte is the remainder, and the incoming high byte is ignored. Example: 0x001E gives 0x0300.
- R10: Divide preparation (op 5): the output low byte is (high byte × 10 + low byte) mod 256 and the output high byte is 0. Example: 0x0307 gives 0x0025.
- R11: Ops 4 and 5 pass carry in and half-carry in to the outputs unchanged.
- R12: Op codes 6 and 7 are reserved: the accumulator and both flags pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Correction select: 0 packed add, 1 packed subtract, 2 unpacked add, 3 unpacked subtract, 4 multiply, 5 divide, 6 and 7 reserved |
| acc_i | input | 16 | Accumulator before correction, high byte in bits 15:8 |
| cy_i | input | 1 | Carry flag before correction |
| hc_i | input | 1 | Half-carry flag (carry out of the low digit) before correction |
| acc_o | output | 16 | Corrected accumulator |
| cy_o | output | 1 | Carry flag after correction |
| hc_o | output | 1 | Half-carry flag after correction |

## Verification
The in-line assertions make no assumption about legal decimal digits. Each one checks a relation that holds for every byte value and flag combination. The only exception is the check that the corrected unpacked digit is below ten, which is made only when the half-carry input was clear. The bench therefore draws opcode, accumulator and flags uniformly from a fixed seed, so invalid nibbles, reserved opcodes and flag combinations that cannot follow a real add all occur. Directed cases add the threshold bytes 0x99, 0x9A, 0x9F and 0xA0, as well as 0xFF.

// File: rtl/dau_pkg.sv
package dau_pkg;

   typedef enum logic [2:0] {
      DAU_PACK_ADD  = 3'd0,
      DAU_PACK_SUB  = 3'd1,
      DAU_UNPK_ADD  = 3'd2,
      DAU_UNPK_SUB  = 3'd3,
      DAU_MUL_SPLIT = 3'd4,
      DAU_DIV_JOIN  = 3'd5,
      DAU_RSVD6     = 3'd6,
      DAU_RSVD7     = 3'd7
   } dau_op_e;

endpackage

// File: rtl/dau_packed_adj.sv
module dau_packed_adj #(
   parameter int DIGIT_W = 4,
   parameter int RADIX   = 10,
   parameter bit IS_SUB  = 1'b0
) (
   input  logic [2*DIGIT_W-1:0] lo_i,
   input  logic                 cy_i,
   input  logic                 hc_i,
   output logic [2*DIGIT_W-1:0] lo_o,
   output logic                 cy_o,
   output logic                 hc_o
);
   localparam int BYTE_W = 2 * DIGIT_W;
   localparam logic [DIGIT_W-1:0] DIG_MAX  = DIGIT_W'(RADIX - 1);
   localparam logic [BYTE_W-1:0]  LO_CORR  = BYTE_W'((1 << DIGIT_W) - RADIX);
   localparam logic [BYTE_W-1:0]  HI_CORR  = BYTE_W'(((1 << DIGIT_W) - RADIX) << DIGIT_W);
   // add: both digits at their maximum; subtract: top digit at its maximum, any low nibble
   localparam logic [BYTE_W-1:0]  ADD_LIM  = BYTE_W'(((RADIX - 1) << DIGIT_W) + (RADIX - 1));
   localparam logic [BYTE_W-1:0]  SUB_LIM  = BYTE_W'(((RADIX - 1) << DIGIT_W) + ((1 << DIGIT_W) - 1));

   if (DIGIT_W < 2) begin : g_bad_width
      $error("dau_packed_adj: DIGIT_W must be at least 2");
   end
   if (RADIX < 2 || RADIX >= (1 << DIGIT_W)) begin : g_bad_radix
      $error("dau_packed_adj: RADIX must lie in 2 .. 2**DIGIT_W-1");
   end

   logic                lo_fix;
   logic                hi_fix;
   logic [BYTE_W-1:0]   stage;

   assign lo_fix = (lo_i[DIGIT_W-1:0] > DIG_MAX) || hc_i;

   if (IS_SUB) begin : g_sub
      assign hi_fix = (lo_i > SUB_LIM) || cy_i;
      assign stage  = lo_fix ? (lo_i - LO_CORR) : lo_i;
      assign lo_o   = hi_fix ? (stage - HI_CORR) : stage;
   end else begin : g_add
      assign hi_fix = (lo_i > ADD_LIM) || cy_i;
      assign stage  = lo_fix ? (lo_i + LO_CORR) : lo_i;
      assign lo_o   = hi_fix ? (stage + HI_CORR) : stage;
   end

   assign hc_o = lo_fix;
   assign cy_o = hi_fix;

   always_comb begin
      // R1 / R3: with no low correction the low nibble is untouched
      if (!hc_o) begin
         p_low_kept_r1: assert (lo_o[DIGIT_W-1:0] == lo_i[DIGIT_W-1:0])
            else $error("low nibble changed without correction");
      end
      // R2 / R4: an incoming carry always survives the correction
      if (cy_i) begin
         p_carry_kept_r2: assert (cy_o)
            else $error("incoming carry dropped");
      end
      // R4: no flags and no correction means the byte passes unchanged
      if (!cy_o && !hc_o) begin
         p_no_fix_same_r4: assert (lo_o == lo_i)
            else $error("byte changed with no correction");
      end
   end

endmodule

// File: rtl/dau_unpacked_adj.sv
module dau_unpacked_adj #(
   parameter int DIGIT_W = 4,
   parameter int RADIX   = 10,
   parameter bit IS_SUB  = 1'b0
) (
   input  logic [2*DIGIT_W-1:0] hi_i,
   input  logic [2*DIGIT_W-1:0] lo_i,
   input  logic                 hc_i,
   output logic [2*DIGIT_W-1:0] hi_o,
   output logic [2*DIGIT_W-1:0] lo_o,
   output logic                 fix_o
);
   localparam int BYTE_W = 2 * DIGIT_W;
   localparam logic [DIGIT_W-1:0] DIG_MAX = DIGIT_W'(RADIX - 1);
   localparam logic [BYTE_W-1:0]  LO_CORR = BYTE_W'((1 << DIGIT_W) - RADIX);
   localparam logic [BYTE_W-1:0]  ONE     = BYTE_W'(1);

   if (RADIX < 2 || RADIX >= (1 << DIGIT_W)) begin : g_bad_radix
      $error("dau_unpacked_adj: RADIX must lie in 2 .. 2**DIGIT_W-1");
   end

   logic              fix;
   logic [BYTE_W-1:0] stage;

   assign fix = (lo_i[DIGIT_W-1:0] > DIG_MAX) || hc_i;

   if (IS_SUB) begin : g_sub
      assign stage = fix ? (lo_i - LO_CORR) : lo_i;
      assign hi_o  = fix ? (hi_i - ONE) : hi_i;
   end else begin : g_add
      assign stage = fix ? (lo_i + LO_CORR) : lo_i;
      assign hi_o  = fix ? (hi_i + ONE) : hi_i;
   end

   assign lo_o  = {{DIGIT_W{1'b0}}, stage[DIGIT_W-1:0]};
   assign fix_o = fix;

   always_comb begin
      p_hi_nib_clear_r8: assert (lo_o[BYTE_W-1:DIGIT_W] == '0)
         else $error("upper nibble of unpacked digit not cleared");
      // R6 / R7: high byte moves by exactly the correction indicator
      if (IS_SUB) begin
         p_borrow_hi_r7: assert (BYTE_W'(hi_i - hi_o) == BYTE_W'(fix_o))
            else $error("high byte borrow mismatch");
      end else begin
         p_carry_hi_r6: assert (BYTE_W'(hi_o - hi_i) == BYTE_W'(fix_o))
            else $error("high byte carry mismatch");
      end
      if (!hc_i) begin
         p_digit_valid_r8: assert (lo_o[DIGIT_W-1:0] <= DIG_MAX)
            else $error("corrected digit out of range");
      end
   end

endmodule

// File: rtl/dau_radix_adj.sv
module dau_radix_adj #(
   parameter int DIGIT_W = 4,
   parameter int RADIX   = 10
) (
   input  logic [2*DIGIT_W-1:0] hi_i,
   input  logic [2*DIGIT_W-1:0] lo_i,
   output logic [2*DIGIT_W-1:0] split_hi_o,
   output logic [2*DIGIT_W-1:0] split_lo_o,
   output logic [2*DIGIT_W-1:0] join_o
);
   localparam int BYTE_W = 2 * DIGIT_W;
   localparam logic [BYTE_W-1:0] RAD = BYTE_W'(RADIX);

   if (RADIX < 2 || RADIX >= (1 << DIGIT_W)) begin : g_bad_radix
      $error("dau_radix_adj: RADIX must lie in 2 .. 2**DIGIT_W-1");
   end

   assign split_hi_o = lo_i / RAD;
   assign split_lo_o = lo_i % RAD;
   assign join_o     = BYTE_W'(hi_i * RAD) + lo_i;

   always_comb begin
      p_split_exact_r9: assert ((2*BYTE_W)'(split_hi_o) * (2*BYTE_W)'(RADIX)
                                + (2*BYTE_W)'(split_lo_o) == (2*BYTE_W)'(lo_i))
         else $error("split does not recompose");
      p_split_digit_r9: assert (split_lo_o < RAD)
         else $error("units digit out of range");
   end

endmodule

// File: rtl/decimal_adjust_unit.sv
module decimal_adjust_unit #(
   parameter int DIGIT_W = 4,
   parameter int RADIX   = 10
) (
   input  logic [2:0]             op_i,
   input  logic [4*DIGIT_W-1:0]   acc_i,
   input  logic                   cy_i,
   input  logic                   hc_i,
   output logic [4*DIGIT_W-1:0]   acc_o,
   output logic                   cy_o,
   output logic                   hc_o
);
   import dau_pkg::*;

   localparam int BYTE_W = 2 * DIGIT_W;

   logic [BYTE_W-1:0] hi_in, lo_in;
   assign hi_in = acc_i[2*BYTE_W-1:BYTE_W];
   assign lo_in = acc_i[BYTE_W-1:0];

   logic [BYTE_W-1:0] pa_lo, ps_lo;
   logic              pa_cy, pa_hc, ps_cy, ps_hc;
   logic [BYTE_W-1:0] ua_hi, ua_lo, us_hi, us_lo;
   logic              ua_fix, us_fix;
   logic [BYTE_W-1:0] sp_hi, sp_lo, jn_lo;

   dau_packed_adj #(.DIGIT_W(DIGIT_W), .RADIX(RADIX), .IS_SUB(1'b0)) u_pack_add (
      .lo_i(lo_in), .cy_i(cy_i), .hc_i(hc_i),
      .lo_o(pa_lo), .cy_o(pa_cy), .hc_o(pa_hc)
   );

   dau_packed_adj #(.DIGIT_W(DIGIT_W), .RADIX(RADIX), .IS_SUB(1'b1)) u_pack_sub (
      .lo_i(lo_in), .cy_i(cy_i), .hc_i(hc_i),
      .lo_o(ps_lo), .cy_o(ps_cy), .hc_o(ps_hc)
   );

   dau_unpacked_adj #(.DIGIT_W(DIGIT_W), .RADIX(RADIX), .IS_SUB(1'b0)) u_unpk_add (
      .hi_i(hi_in), .lo_i(lo_in), .hc_i(hc_i),
      .hi_o(ua_hi), .lo_o(ua_lo), .fix_o(ua_fix)
   );

   dau_unpacked_adj #(.DIGIT_W(DIGIT_W), .RADIX(RADIX), .IS_SUB(1'b1)) u_unpk_sub (
      .hi_i(hi_in), .lo_i(lo_in), .hc_i(hc_i),
      .hi_o(us_hi), .lo_o(us_lo), .fix_o(us_fix)
   );

   dau_radix_adj #(.DIGIT_W(DIGIT_W), .RADIX(RADIX)) u_radix (
      .hi_i(hi_in), .lo_i(lo_in),
      .split_hi_o(sp_hi), .split_lo_o(sp_lo), .join_o(jn_lo)
   );

   always_comb begin
      acc_o = acc_i;
      cy_o  = cy_i;
      hc_o  = hc_i;
      unique case (dau_op_e'(op_i))
         DAU_PACK_ADD: begin
            acc_o = {hi_in, pa_lo};
            cy_o  = pa_cy;
            hc_o  = pa_hc;
         end
         DAU_PACK_SUB: begin
            acc_o = {hi_in, ps_lo};
            cy_o  = ps_cy;
            hc_o  = ps_hc;
         end
         DAU_UNPK_ADD: begin
            acc_o = {ua_hi, ua_lo};
            cy_o  = ua_fix;
            hc_o  = ua_fix;
         end
         DAU_UNPK_SUB: begin
            acc_o = {us_hi, us_lo};
            cy_o  = us_fix;
            hc_o  = us_fix;
         end
         DAU_MUL_SPLIT: acc_o = {sp_hi, sp_lo};
         DAU_DIV_JOIN:  acc_o = {{BYTE_W{1'b0}}, jn_lo};
         DAU_RSVD6, DAU_RSVD7: ;
         default: ;
      endcase
   end

   always_comb begin
      if (op_i == 3'd0 || op_i == 3'd1) begin
         p_pack_hi_kept_r5: assert (acc_o[2*BYTE_W-1:BYTE_W] == hi_in)
            else $error("packed correction touched high byte");
      end
      if (op_i == 3'd2 || op_i == 3'd3) begin
         p_unpk_flags_eq_r8: assert (cy_o == hc_o)
            else $error("unpacked flags differ");
      end
      if (op_i == 3'd4 || op_i == 3'd5) begin
         p_flags_pass_r11: assert (cy_o == cy_i && hc_o == hc_i)
            else $error("flags changed by multiply/divide correction");
      end
      if (op_i == 3'd5) begin
         p_div_hi_zero_r10: assert (acc_o[2*BYTE_W-1:BYTE_W] == '0)
            else $error("high byte not cleared");
      end
      if (op_i[2:1] == 2'b11) begin
         p_rsvd_pass_r12: assert (acc_o == acc_i && cy_o == cy_i && hc_o == hc_i)
            else $error("reserved op altered state");
      end
   end

endmodule

// File: tb/decimal_adjust_unit_tb.sv
module decimal_adjust_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op;
   logic [15:0] acc;
   logic        cy, hc;
   logic [15:0] acc_out;
   logic        cy_out, hc_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   decimal_adjust_unit u_dut (
      .op_i(op), .acc_i(acc), .cy_i(cy), .hc_i(hc),
      .acc_o(acc_out), .cy_o(cy_out), .hc_o(hc_out)
   );

   // returns {acc, cy, hc}
   function automatic logic [17:0] model(input logic [2:0] o, input logic [15:0] a,
                                         input logic c, input logic h);
      logic [7:0] hi, lo, lo0;
      logic       c2, h2, lf, hf;
      hi = a[15:8]; lo = a[7:0]; lo0 = lo; c2 = c; h2 = h;
      lf = (lo[3:0] > 4'd9) || h;
      case (o)
         3'd0: begin
            hf = (lo0 > 8'h99) || c;
            if (lf) lo = lo + 8'h06;
            if (hf) lo = lo + 8'h60;
            c2 = hf; h2 = lf;
         end
         3'd1: begin
            hf = (lo0 > 8'h9F) || c;
            if (lf) lo = lo - 8'h06;
            if (hf) lo = lo - 8'h60;
            c2 = hf; h2 = lf;
         end
         3'd2: begin
            if (lf) begin lo = lo + 8'h06; hi = hi + 8'h01; end
            lo = lo & 8'h0F; c2 = lf; h2 = lf;
         end
         3'd3: begin
            if (lf) begin lo = lo - 8'h06; hi = hi - 8'h01; end
            lo = lo & 8'h0F; c2 = lf; h2 = lf;
         end
         3'd4: begin
            hi = lo0 / 8'd10; lo = lo0 % 8'd10;
         end
         3'd5: begin
            lo = 8'((int'(hi) * 10 + int'(lo0)) % 256); hi = 8'h00;
         end
         default: ;
      endcase
      return {hi, lo, c2, h2};
   endfunction

   function automatic string tag_of(input logic [2:0] o);
      case (o)
         3'd0: return "R1 R2 R5";
         3'd1: return "R3 R4 R5";
         3'd2: return "R6 R8";
         3'd3: return "R7 R8";
         3'd4: return "R9 R11";
         3'd5: return "R10 R11";
         default: return "R12";
      endcase
   endfunction

   task automatic apply(input logic [2:0] o, input logic [15:0] a,
                        input logic c, input logic h, input string req);
      logic [17:0] exp_v;
      @(negedge clk);
      op = o; acc = a; cy = c; hc = h;
      @(posedge clk);
      #1;
      exp_v = model(o, a, c, h);
      n_checks++;
      if ({acc_out, cy_out, hc_out} !== exp_v) begin
         n_fail++;
         $display("FAIL %s op=%0d in=%h cy=%b hc=%b : got acc=%h cy=%b hc=%b exp acc=%h cy=%b hc=%b",
                  req, o, a, c, h, acc_out, cy_out, hc_out, exp_v[17:2], exp_v[1], exp_v[0]);
      end
   endtask

   // directed check against a hand-worked value
   task automatic expect_val(input logic [2:0] o, input logic [15:0] a, input logic c,
                             input logic h, input logic [15:0] ea, input logic ec,
                             input logic eh, input string req);
      @(negedge clk);
      op = o; acc = a; cy = c; hc = h;
      @(posedge clk);
      #1;
      n_checks++;
      if ({acc_out, cy_out, hc_out} !== {ea, ec, eh}) begin
         n_fail++;
         $display("FAIL %s op=%0d in=%h : got acc=%h cy=%b hc=%b exp acc=%h cy=%b hc=%b",
                  req, o, a, acc_out, cy_out, hc_out, ea, ec, eh);
      end
   endtask

   initial begin
      op = 3'd0; acc = 16'h0000; cy = 1'b0; hc = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset-time state: zero inputs give zero outputs
      expect_val(3'd0, 16'h0000, 0, 0, 16'h0000, 0, 0, "R1 reset");
      // R1 R2 packed add
      expect_val(3'd0, 16'h117D, 0, 0, 16'h1183, 0, 1, "R1 R5");
      expect_val(3'd0, 16'h009A, 0, 0, 16'h0000, 1, 1, "R2");
      expect_val(3'd0, 16'h0092, 0, 1, 16'h0098, 0, 1, "R1");
      expect_val(3'd0, 16'h0099, 0, 0, 16'h0099, 0, 0, "R2 boundary");
      expect_val(3'd0, 16'h0012, 1, 0, 16'h0072, 1, 0, "R2 carry in");
      // R3 R4 packed subtract
      expect_val(3'd1, 16'h00F9, 1, 1, 16'h0093, 1, 1, "R4");
      expect_val(3'd1, 16'h222D, 0, 0, 16'h2227, 0, 1, "R3 R5");
      expect_val(3'd1, 16'h009F, 0, 0, 16'h0099, 0, 1, "R4 boundary");
      expect_val(3'd1, 16'h00A0, 0, 0, 16'h0040, 1, 0, "R4 above");
      // R6 R7 R8 unpacked
      expect_val(3'd2, 16'h006A, 0, 0, 16'h0100, 1, 1, "R6");
      expect_val(3'd2, 16'h0035, 1, 0, 16'h0005, 0, 0, "R8 clear nibble");
      expect_val(3'd2, 16'hFF0C, 0, 0, 16'h0002, 1, 1, "R6 wrap");
      expect_val(3'd3, 16'h00FF, 0, 0, 16'hFF09, 1, 1, "R7");
      expect_val(3'd3, 16'h0538, 0, 0, 16'h0508, 0, 0, "R7 R8 none");
      // R9 R10 R11
      expect_val(3'd4, 16'h001E, 0, 0, 16'h0300, 0, 0, "R9");
      expect_val(3'd4, 16'hAAFF, 1, 1, 16'h1905, 1, 1, "R9 R11");
      expect_val(3'd5, 16'h0307, 0, 0, 16'h0025, 0, 0, "R10");
      expect_val(3'd5, 16'h0909, 1, 0, 16'h0063, 1, 0, "R10 R11");
      expect_val(3'd5, 16'h1A10, 0, 1, 16'h0014, 0, 1, "R10 wrap");
      // R12 reserved
      expect_val(3'd6, 16'hBEEF, 1, 0, 16'hBEEF, 1, 0, "R12");
      expect_val(3'd7, 16'h1234, 0, 1, 16'h1234, 0, 1, "R12");
      // random sweep, fixed seed
      begin
         int unsigned seed_v;
         seed_v = $urandom(32'h5EED_0BCD);
         for (int i = 0; i < N_RANDOM; i++) begin
            logic [2:0]  ro;
            logic [15:0] ra;
            logic        rc, rh;
            ro = 3'($urandom_range(0, 7));
            ra = 16'($urandom);
            rc = 1'($urandom);
            rh = 1'($urandom);
            apply(ro, ra, rc, rh, tag_of(ro));
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R12 run did not finish: got timeout exp completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule